// File: doc/BRIEF.md
# Clock Failure Recovery Controller

This block takes the verdict of an oscillator failure detector and turns it into a safe clock configuration. When the detector reports a failure event, the controller overrides the main-clock source selection so that the main clock comes from the fast RC oscillator. If the master clock was running from a PLL fed by the crystal, it first moves the master clock onto the main clock. It also forces the fast RC oscillator on. The switch is sequenced in two or three cycles of the slow clock that drives the block, depending on where the master clock was running.

At the same time the block latches a fault output for the protection input of a PWM controller. That output stays high until the failure has gone away and software has written a clear. A sticky event flag records that a failure occurred. It drives a maskable interrupt and is cleared by a status read. Live detector status, the flag and the fault output are available as separate status bits. The glitch-free clock multiplexers themselves sit outside this block. They consume its overridden selections.

Encodings: the main-clock select is 1 for the crystal and 0 for the fast RC oscillator. The master-clock select code is 0 for the slow clock, 1 for the main clock, and 2 or 3 for a PLL.

Top module: `cfr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `fault_out`, `stat_evt` and `irq` are 0, and `main_sel_out`, `mck_sel_out` and `rc_en_out` equal their inputs.
- R2: A failure event sampled at edge k, when not (main select = 1 and master code 2 or 3), drives `main_sel_out` to 0 after edge k+1 but not after edge k. `mck_sel_out` keeps following `mck_sel_in`.
- R3: A failure event sampled at edge k, with main select = 1 and master code 2 or 3 at that edge, drives `mck_sel_out` to 1 after edge k+1 and `main_sel_out` to 0 after edge k+2.
- R4: From the edge that applies the first override until the overrides are released, `rc_en_out` is 1 whatever `rc_en_in` is.
- R5: A failure event sets `stat_evt` at the next edge. A status read clears it at the next edge. An event and a read in the same cycle leave it set.
- R6: `irq` equals `stat_evt` AND `irq_en`.
- R7: A failure event sets `fault_out` at the next edge. `fault_out` falls only at an edge where `fault_clr` is 1, `fail_live` is 0 and no event is present. A clear while `fail_live` is 1 leaves it set.
- R8: Once the sequence has finished, all overrides are released one edge after `fault_out` falls. From then on the outputs follow their inputs again, unless a new event arrives.
- R9: `stat_live` follows `fail_live` and `stat_fault` follows `fault_out` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_evt | input | 1 | Failure event from detector (one-cycle) |
| fail_live | input | 1 | Detector's present failure status |
| main_sel_in | input | 1 | Configured main-clock source (1 crystal, 0 fast RC) |
| mck_sel_in | input | MCK_W | Configured master-clock source code |
| rc_en_in | input | 1 | Configured fast RC enable |
| irq_en | input | 1 | Interrupt mask enable |
| sr_rd | input | 1 | Status-register read strobe |
| fault_clr | input | 1 | Fault-clear write strobe |
| main_sel_out | output | 1 | Main-clock source after override |
| mck_sel_out | output | MCK_W | Master-clock source after override |
| rc_en_out | output | 1 | Fast RC enable after force |
| irq | output | 1 | Failure interrupt |
| fault_out | output | 1 | Latched fault for PWM protection |
| stat_evt | output | 1 | Sticky event flag |
| stat_live | output | 1 | Live detector status |
| stat_fault | output | 1 | Fault output status |

## Verification
The switchover is tried with failures arriving under every pairing of main source and master code. This separates the two-step path from the three-step path and shows that the PLL path is chosen only from the configuration at the event edge. Random clear and read strobes land while the failure is still live, right after it ends, and in the same cycle as a new event. This shows that the fault latch needs both conditions and that set beats clear for the flag. Toggling the mask and the configured inputs while overrides are held shows that the overrides, not the inputs, drive the outputs until release.

// File: rtl/cfr_pkg.sv
// Package: shared encodings for the clock failure recovery controller.
// Assumes the main-clock select is one bit where 1 means crystal.
package cfr_pkg;
    localparam logic MAIN_XTAL = 1'b1;
    localparam logic MAIN_FRC  = 1'b0;

    // Recovery sequence states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DET  = 2'd1,
        ST_MCK  = 2'd2,
        ST_HOLD = 2'd3
    } seq_st_e;
endpackage

// File: rtl/cfr_fault.sv
// Module: cfr_fault
// Latches the fault output on a failure event. The latch drops only when a
// clear strobe arrives while the failure is absent.
// Assumes fail_evt is a single-cycle pulse synchronous to clk.
module cfr_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    input  logic fail_live,
    input  logic fault_clr,
    output logic fault_q
);
    logic clr_ok;

    // Clear is accepted only when the failure is gone and no event is present
    always_comb begin
        clr_ok = fault_clr && !fail_live && !fail_evt;
    end

    // Fault latch: set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (fail_evt) begin
            fault_q <= 1'b1;
        end else if (clr_ok) begin
            fault_q <= 1'b0;
        end
    end

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> fault_q); // R7
    AST_FAULT_KEEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && fail_live) |=> fault_q); // R7
    AST_FAULT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> ($past(fault_clr) && !$past(fail_live))); // R7
endmodule

// File: rtl/cfr_evt.sv
// Module: cfr_evt
// Sticky failure-event flag with read-to-clear and a masked interrupt.
// Assumes sr_rd is a one-cycle strobe per status-register read.
module cfr_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    input  logic sr_rd,
    input  logic irq_en,
    output logic evt_q,
    output logic irq
);
    // Event flag: a new event beats a simultaneous read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (fail_evt) begin
            evt_q <= 1'b1;
        end else if (sr_rd) begin
            evt_q <= 1'b0;
        end
    end

    // Interrupt gating by the mask enable
    always_comb begin
        irq = evt_q & irq_en;
    end

    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> evt_q); // R5
    AST_EVT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_q) |-> $past(sr_rd)); // R5
endmodule

// File: rtl/cfr_seq.sv
// Module: cfr_seq
// Sequences the clock-source overrides after a failure event. On the PLL path
// the master clock is moved to the main clock one cycle before the main clock
// is moved to the fast RC. Overrides are held until the fault latch clears.
// Assumes fault_act is the registered fault output of cfr_fault.
module cfr_seq
    import cfr_pkg::*;
#(
    parameter int MCK_W    = 2,
    parameter int MCK_MAIN = 1,
    parameter int PLL_LO   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_evt,
    input  logic             fault_act,
    input  logic             main_sel_in,
    input  logic [MCK_W-1:0] mck_sel_in,
    input  logic             rc_en_in,
    output logic             main_sel_out,
    output logic [MCK_W-1:0] mck_sel_out,
    output logic             rc_en_out
);
    localparam logic [MCK_W-1:0] MCK_MAIN_C = MCK_W'(MCK_MAIN);
    localparam logic [MCK_W-1:0] PLL_LO_C   = MCK_W'(PLL_LO);

    seq_st_e st_q, st_d;
    logic    pll_q;
    logic    pll_now;
    logic    ovr_act;

    // Decide at the event edge whether the master clock runs from a crystal PLL
    always_comb begin
        pll_now = (main_sel_in == MAIN_XTAL) && (mck_sel_in >= PLL_LO_C);
    end

    // Next-state logic of the recovery sequence
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (fail_evt) st_d = ST_DET;
            ST_DET:  st_d = pll_q ? ST_MCK : ST_HOLD;
            ST_MCK:  st_d = ST_HOLD;
            ST_HOLD: if (!fail_evt && !fault_act) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State and path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pll_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && fail_evt) begin
                pll_q <= pll_now;
            end
        end
    end

    // Override application from the current sequence state
    always_comb begin
        ovr_act      = (st_q == ST_MCK) || (st_q == ST_HOLD);
        main_sel_out = (st_q == ST_HOLD) ? MAIN_FRC : main_sel_in;
        mck_sel_out  = (ovr_act && pll_q) ? MCK_MAIN_C : mck_sel_in;
        rc_en_out    = rc_en_in | ovr_act;
    end

    AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DET) |=> (st_q == ST_MCK || st_q == ST_HOLD)); // R2
    AST_MCK_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MCK) |=> (st_q == ST_HOLD)); // R3
    AST_HOLD_WHILE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && fault_act) |=> (st_q == ST_HOLD)); // R8
endmodule

// File: rtl/cfr_ctrl.sv
// Module: cfr_ctrl (top)
// Clock failure recovery controller: override sequencing, fault latch,
// sticky event flag with interrupt, and status bits.
// Assumes all inputs are synchronous to the slow clock clk.
module cfr_ctrl #(
    parameter int MCK_W    = 2,
    parameter int MCK_MAIN = 1,
    parameter int PLL_LO   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_evt,
    input  logic             fail_live,
    input  logic             main_sel_in,
    input  logic [MCK_W-1:0] mck_sel_in,
    input  logic             rc_en_in,
    input  logic             irq_en,
    input  logic             sr_rd,
    input  logic             fault_clr,
    output logic             main_sel_out,
    output logic [MCK_W-1:0] mck_sel_out,
    output logic             rc_en_out,
    output logic             irq,
    output logic             fault_out,
    output logic             stat_evt,
    output logic             stat_live,
    output logic             stat_fault
);
    localparam logic [MCK_W-1:0] MCK_MAIN_C = MCK_W'(MCK_MAIN);

    logic fault_q;
    logic evt_q;

    cfr_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_evt  (fail_evt),
        .fail_live (fail_live),
        .fault_clr (fault_clr),
        .fault_q   (fault_q)
    );

    cfr_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_evt (fail_evt),
        .sr_rd    (sr_rd),
        .irq_en   (irq_en),
        .evt_q    (evt_q),
        .irq      (irq)
    );

    cfr_seq #(
        .MCK_W    (MCK_W),
        .MCK_MAIN (MCK_MAIN),
        .PLL_LO   (PLL_LO)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_evt     (fail_evt),
        .fault_act    (fault_q),
        .main_sel_in  (main_sel_in),
        .mck_sel_in   (mck_sel_in),
        .rc_en_in     (rc_en_in),
        .main_sel_out (main_sel_out),
        .mck_sel_out  (mck_sel_out),
        .rc_en_out    (rc_en_out)
    );

    // Status and fault outputs
    always_comb begin
        fault_out  = fault_q;
        stat_evt   = evt_q;
        stat_fault = fault_q;
        stat_live  = fail_live;
    end

    AST_RC_WITH_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (main_sel_out != main_sel_in) |-> rc_en_out); // R4
    AST_MCK_ONLY_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_sel_out != mck_sel_in) |-> (mck_sel_out == MCK_MAIN_C)); // R3
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R6
endmodule

// File: tb/cfr_ctrl_tb.sv
module cfr_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fail_evt = 0, fail_live = 0, main_sel_in = 0, rc_en_in = 0;
    logic       irq_en = 0, sr_rd = 0, fault_clr = 0;
    logic [1:0] mck_sel_in = 0;
    logic       main_sel_out, rc_en_out, irq, fault_out, stat_evt, stat_live, stat_fault;
    logic [1:0] mck_sel_out;

    int total = 0;
    int bad = 0;

    // Bench reference state
    int   m_ph = 0;
    logic m_pll = 0, m_evt = 0, m_fault = 0;

    always #5 clk = ~clk;

    cfr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fail_evt(fail_evt), .fail_live(fail_live),
        .main_sel_in(main_sel_in), .mck_sel_in(mck_sel_in), .rc_en_in(rc_en_in),
        .irq_en(irq_en), .sr_rd(sr_rd), .fault_clr(fault_clr),
        .main_sel_out(main_sel_out), .mck_sel_out(mck_sel_out), .rc_en_out(rc_en_out),
        .irq(irq), .fault_out(fault_out), .stat_evt(stat_evt),
        .stat_live(stat_live), .stat_fault(stat_fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_main();
        return (m_ph == 3) ? 0 : int'(main_sel_in);
    endfunction
    function automatic int exp_mck();
        return (m_ph >= 2 && m_pll) ? 1 : int'(mck_sel_in);
    endfunction
    function automatic int exp_rc();
        return (rc_en_in || m_ph >= 2) ? 1 : 0;
    endfunction

    // Reference update from the inputs present at the edge
    task automatic model_edge();
        logic f_old;
        f_old = m_fault;
        case (m_ph)
            0: if (fail_evt) begin m_ph = 1; m_pll = main_sel_in && mck_sel_in[1]; end
            1: m_ph = m_pll ? 2 : 3;
            2: m_ph = 3;
            default: if (!fail_evt && !f_old) m_ph = 0;
        endcase
        if (fail_evt) m_fault = 1;
        else if (fault_clr && !fail_live) m_fault = 0;
        if (fail_evt) m_evt = 1;
        else if (sr_rd) m_evt = 0;
    endtask

    task automatic check_all();
        chk("R2 main_sel_out", int'(main_sel_out), exp_main());
        chk("R3 mck_sel_out", int'(mck_sel_out), exp_mck());
        chk("R4 rc_en_out", int'(rc_en_out), exp_rc());
        chk("R5 stat_evt", int'(stat_evt), int'(m_evt));
        chk("R6 irq", int'(irq), int'(m_evt && irq_en));
        chk("R7 fault_out", int'(fault_out), int'(m_fault));
        chk("R9 stat_fault", int'(stat_fault), int'(m_fault));
        chk("R9 stat_live", int'(stat_live), int'(fail_live));
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic quiet();
        fail_evt = 0; sr_rd = 0; fault_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        main_sel_in = 1; mck_sel_in = 2; rc_en_in = 0; irq_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with pass-through outputs
        chk("R1 fault_out", int'(fault_out), 0);
        chk("R1 stat_evt", int'(stat_evt), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 main pass", int'(main_sel_out), 1);
        chk("R1 mck pass", int'(mck_sel_out), 2);
        chk("R1 rc pass", int'(rc_en_out), 0);
        rst_n = 1;

        // R2: master on main clock, two-edge switchover
        main_sel_in = 1; mck_sel_in = 1; fail_evt = 1; fail_live = 1;
        step(); quiet();
        chk("R2 not yet after k", int'(main_sel_out), 1);
        step();
        chk("R2 switched after k+1", int'(main_sel_out), 0);
        chk("R4 rc forced", int'(rc_en_out), 1);
        // R7: clear while live is ignored
        fault_clr = 1; step(); quiet();
        chk("R7 clear while live", int'(fault_out), 1);
        // R8: release after clear once failure is gone
        fail_live = 0; fault_clr = 1; step(); quiet();
        chk("R8 fault dropped", int'(fault_out), 0);
        chk("R8 override still held", int'(main_sel_out), 0);
        step();
        chk("R8 override released", int'(main_sel_out), 1);
        // R5: event and read together keep the flag
        sr_rd = 1; step(); quiet();
        chk("R5 read clears", int'(stat_evt), 0);
        fail_evt = 1; sr_rd = 1; fail_live = 1; step(); quiet();
        chk("R5 event wins read", int'(stat_evt), 1);
        step(); step();
        fail_live = 0; fault_clr = 1; step(); quiet(); step();
        sr_rd = 1; step(); quiet();

        // R3: crystal PLL path, three-edge switchover
        main_sel_in = 1; mck_sel_in = 3; fail_evt = 1; fail_live = 1;
        step(); quiet();
        chk("R3 mck not yet", int'(mck_sel_out), 3);
        step();
        chk("R3 mck to main after k+1", int'(mck_sel_out), 1);
        chk("R3 main kept after k+1", int'(main_sel_out), 1);
        step();
        chk("R3 main to RC after k+2", int'(main_sel_out), 0);
        fail_live = 0; fault_clr = 1; step(); quiet(); step(); step();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            fail_evt  = ($urandom % 20) == 0;
            if (($urandom % 10) == 0) fail_live = ~fail_live;
            if (fail_evt) fail_live = 1;
            fault_clr = ($urandom % 5) == 0;
            sr_rd     = ($urandom % 6) == 0;
            irq_en    = ($urandom % 4) != 0;
            if (($urandom % 8) == 0) main_sel_in = 1'($urandom);
            if (($urandom % 8) == 0) mck_sel_in  = 2'($urandom);
            if (($urandom % 8) == 0) rc_en_in    = 1'($urandom);
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule